// File: doc/BRIEF.md
# Masked XOR Scan-Unload Compactor

This block sits between the unload ends of many parallel scan chains and a small number of tester output channels. On every shift cycle it takes one bit from each chain, removes the bits the tester has declared unknown, and folds the remaining bits through XOR trees into a few compacted output bits. A single unknown value that reached an XOR tree would spoil the whole compacted result, so unknowns have to be blocked before the fold.

Two mask registers are kept inside the block, each holding one bit per chain. Both are preloaded serially before the unload of a pattern begins, while scan shifting is idle. A 2-bit mask-select code then chooses, cycle by cycle, which of the two registers gates the chains. A gated chain contributes a constant 0 to its tree. Good data on a gated chain is lost as well, and that loss is accepted.

Top module: `xor_mask_compactor`

## Requirements
- R1: With mask-select code 00 and scan_en high, output bit j is the XOR of every chain whose index i satisfies i mod NUM_OUTS == j. With the default 2 outputs, even chains feed bit 0 and odd chains feed bit 1.
- R2: Outputs are registered. The compacted value of the chain bits sampled at a rising clock edge appears after that edge and holds until the next edge.
- R3: A clock edge with scan_en low drives every output bit to 0.
- R4: Code 01 gates every chain whose mask-0 bit is 1, and code 10 gates every chain whose mask-1 bit is 1. A gated chain contributes 0 to its XOR tree.
- R5: Code 11 gates a chain when either its mask-0 bit or its mask-1 bit is 1.
- R6: Any value on a gated chain, including corrupted or unknown-like data, has no effect on the outputs. Corruption on an ungated chain does reach the outputs.
- R7: While scan_en is low and mload_en is high, each clock shifts mload_data into the register chosen by mload_sel (0 = mask 0, 1 = mask 1). The new bit enters at the top index and moves toward index 0, so after NUM_CHAINS shifts the first bit sent sits at index 0.
- R8: load_done[k] (k = 0 for mask 0, k = 1 for mask 1) is 0 after NUM_CHAINS-1 load shifts into register k and 1 after NUM_CHAINS shifts. It is cleared by any clock edge with scan_en high.
- R9: Load requests made while scan_en is high leave both mask registers unchanged.
- R10: After reset, the outputs are 0, both done flags are 0 and both mask registers are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | High during unload shifting; low during mask loading and idle |
| chain_in | input | NUM_CHAINS | One unload bit per scan chain |
| mask_sel | input | 2 | Per-cycle gating code: 00 none, 01 mask 0, 10 mask 1, 11 either |
| mload_en | input | 1 | Serial mask-load shift request |
| mload_sel | input | 1 | Target register of the load: 0 mask 0, 1 mask 1 |
| mload_data | input | 1 | Serial mask-load bit |
| load_done | output | 2 | Per-register full-load flag |
| comp_out | output | NUM_OUTS | Registered compacted output channels |

## Verification
The bench builds the block with its defaults: 16 chains folded into 2 outputs, which gives 8 chains per tree. With a 16-bit mask, a probe can walk a single 1 across every chain index. That walk checks every mask bit position after a serial load and the even/odd interleave of the trees. Loads take only 16 clocks, so the bench can observe the done flag's boundary at shifts 15 and 16 directly. It can also run corruption on gated and ungated chains under each gating code.

// File: rtl/xor_mask_compactor.sv
module xor_mask_compactor #(
  parameter int NUM_CHAINS = 16,
  parameter int NUM_OUTS   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_en,
  input  logic [NUM_CHAINS-1:0] chain_in,
  input  logic [1:0]            mask_sel,
  input  logic                  mload_en,
  input  logic                  mload_sel,
  input  logic                  mload_data,
  output logic [1:0]            load_done,
  output logic [NUM_OUTS-1:0]   comp_out
);
  localparam int PER_OUT = NUM_CHAINS / NUM_OUTS;
  localparam int CNT_W   = $clog2(NUM_CHAINS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_CHAINS);

  logic [NUM_CHAINS-1:0] mask_r0, mask_r1;
  logic [CNT_W-1:0]      cnt_r0, cnt_r1;
  logic [NUM_CHAINS-1:0] kill, gated;
  logic [NUM_OUTS-1:0]   fold;

  wire ld0 = !scan_en && mload_en && !mload_sel;
  wire ld1 = !scan_en && mload_en &&  mload_sel;

  assign kill  = ({NUM_CHAINS{mask_sel[0]}} & mask_r0) | ({NUM_CHAINS{mask_sel[1]}} & mask_r1);
  assign gated = chain_in & ~kill;

  for (genvar j = 0; j < NUM_OUTS; j++) begin : g_out
    logic [PER_OUT-1:0] grp;
    for (genvar k = 0; k < PER_OUT; k++) begin : g_tap
      assign grp[k] = gated[k*NUM_OUTS + j];
    end
    assign fold[j] = ^grp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_r0 <= '0;
      mask_r1 <= '0;
    end else begin
      if (ld0) mask_r0 <= {mload_data, mask_r0[NUM_CHAINS-1:1]};
      if (ld1) mask_r1 <= {mload_data, mask_r1[NUM_CHAINS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r0 <= '0;
      cnt_r1 <= '0;
    end else if (scan_en) begin
      cnt_r0 <= '0;
      cnt_r1 <= '0;
    end else begin
      if (ld0 && cnt_r0 != FULL) cnt_r0 <= cnt_r0 + 1'b1;
      if (ld1 && cnt_r1 != FULL) cnt_r1 <= cnt_r1 + 1'b1;
    end
  end

  assign load_done = {cnt_r1 == FULL, cnt_r0 == FULL};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       comp_out <= '0;
    else if (scan_en) comp_out <= fold;
    else              comp_out <= '0;
  end
endmodule

// File: rtl/xor_mask_compactor_chk.sv
module xor_mask_compactor_chk #(
  parameter int NUM_CHAINS = 16,
  parameter int NUM_OUTS   = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scan_en,
  input logic [NUM_CHAINS-1:0] chain_in,
  input logic [1:0]            mask_sel,
  input logic [NUM_CHAINS-1:0] mask0,
  input logic [NUM_CHAINS-1:0] mask1,
  input logic [1:0]            load_done,
  input logic [NUM_OUTS-1:0]   comp_out
);
  function automatic logic [NUM_OUTS-1:0] plain_fold(input logic [NUM_CHAINS-1:0] v);
    logic [NUM_OUTS-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_CHAINS; i++) r[i % NUM_OUTS] ^= v[i];
    return r;
  endfunction

  a_r1_plain_fold: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && mask_sel == 2'b00) |=> comp_out == plain_fold($past(chain_in)));

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> comp_out == '0);

  a_r5_union_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && mask_sel == 2'b11 && (mask0 | mask1) == '1) |=> comp_out == '0);

  a_r8_done_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> load_done == 2'b00);

  a_r9_masks_hold: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> ($stable(mask0) && $stable(mask1)));
endmodule

bind xor_mask_compactor xor_mask_compactor_chk #(
  .NUM_CHAINS(NUM_CHAINS), .NUM_OUTS(NUM_OUTS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .chain_in(chain_in),
  .mask_sel(mask_sel), .mask0(mask_r0), .mask1(mask_r1),
  .load_done(load_done), .comp_out(comp_out)
);

// File: tb/xor_mask_compactor_tb_top.sv
module xor_mask_compactor_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        scan_en = 0;
  logic [15:0] chain_in = '0;
  logic [1:0]  mask_sel = '0;
  logic        mload_en = 0, mload_sel = 0, mload_data = 0;
  logic [1:0]  load_done;
  logic [1:0]  comp_out;

  int errs = 0, checks = 0;
  logic [15:0] m0 = '0, m1 = '0;

  always #5 clk = ~clk;

  xor_mask_compactor dut_i (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .chain_in(chain_in),
    .mask_sel(mask_sel), .mload_en(mload_en), .mload_sel(mload_sel),
    .mload_data(mload_data), .load_done(load_done), .comp_out(comp_out)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model(logic [15:0] ch, logic [1:0] code);
    logic [15:0] kill = (code[0] ? m0 : 16'h0) | (code[1] ? m1 : 16'h0);
    logic [15:0] g = ch & ~kill;
    logic [1:0] r = 2'b00;
    for (int i = 0; i < 16; i++) r[i % 2] ^= g[i];
    return r;
  endfunction

  task automatic shift(logic [1:0] code, logic [15:0] ch, string req);
    @(negedge clk);
    scan_en = 1; mask_sel = code; chain_in = ch; mload_en = 0;
    @(negedge clk);
    chk(req, {14'd0, comp_out}, {14'd0, model(ch, code)});
  endtask

  task automatic load_mask(logic which, logic [15:0] v);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (i == 15) chk("R8 done low after 15 shifts", {15'd0, load_done[which]}, 16'd0);
      scan_en = 0; mload_en = 1; mload_sel = which; mload_data = v[i];
    end
    @(negedge clk);
    mload_en = 0;
    chk("R8 done high after 16 shifts", {15'd0, load_done[which]}, 16'd1);
    if (which) m1 = v; else m0 = v;
  endtask

  task automatic probe(logic which, string req);
    for (int i = 0; i < 16; i++) shift(which ? 2'b10 : 2'b01, 16'h1 << i, req);
  endtask

  task automatic t_reset();
    chk("R10 outputs zero after reset", {14'd0, comp_out}, 16'd0);
    chk("R10 done flags zero after reset", {14'd0, load_done}, 16'd0);
    shift(2'b11, 16'h0001, "R10 masks zero after reset");
    shift(2'b11, 16'h0080, "R10 masks zero after reset");
  endtask

  task automatic t_load();
    load_mask(1'b0, 16'hA5C3);
    load_mask(1'b1, 16'h3C96);
    probe(1'b0, "R7 R4 mask0 bit positions");
    probe(1'b1, "R7 R4 mask1 bit positions");
  endtask

  task automatic t_plain();
    shift(2'b00, 16'h0001, "R1 even chain to out0");
    chk("R1 out0 value", {14'd0, comp_out}, 16'd1);
    shift(2'b00, 16'h0002, "R1 odd chain to out1");
    chk("R1 out1 value", {14'd0, comp_out}, 16'd2);
    shift(2'b00, 16'hFFFF, "R1 all ones");
    shift(2'b00, 16'h1234, "R1 mixed");
    shift(2'b00, 16'h8001, "R1 ends");
  endtask

  task automatic t_latency();
    @(negedge clk);
    scan_en = 1; mask_sel = 2'b00; chain_in = 16'h0001;
    @(negedge clk);
    chk("R2 first value after edge", {14'd0, comp_out}, 16'd1);
    chain_in = 16'h0002;
    #4;
    chk("R2 holds before next edge", {14'd0, comp_out}, 16'd1);
    @(negedge clk);
    chk("R2 second value after edge", {14'd0, comp_out}, 16'd2);
  endtask

  task automatic t_idle();
    shift(2'b00, 16'h0003, "R1 preload nonzero");
    @(negedge clk);
    scan_en = 0; chain_in = 16'hFFFD;
    @(negedge clk);
    chk("R3 idle drives zero", {14'd0, comp_out}, 16'd0);
  endtask

  task automatic t_modes();
    shift(2'b01, 16'hFFFF, "R4 code01 all ones");
    shift(2'b10, 16'hFFFF, "R4 code10 all ones");
    shift(2'b11, 16'hFFFF, "R5 code11 all ones");
    shift(2'b11, 16'h5A5A, "R5 code11 mixed");
    shift(2'b11, 16'h0001, "R5 bit masked by mask0 only");
    chk("R5 union gates chain0", {14'd0, comp_out}, 16'd0);
    shift(2'b11, 16'h0004, "R5 bit masked by mask1 only");
    chk("R5 union gates chain2", {14'd0, comp_out}, 16'd0);
  endtask

  task automatic t_xinject();
    logic [15:0] base = 16'h6B2D;
    shift(2'b01, base ^ (m0 & 16'hFFFF), "R6 corrupt all mask0 chains");
    chk("R6 code01 matches clean", {14'd0, comp_out}, {14'd0, model(base, 2'b01)});
    shift(2'b10, base ^ (m1 & 16'h5555), "R6 corrupt some mask1 chains");
    chk("R6 code10 matches clean", {14'd0, comp_out}, {14'd0, model(base, 2'b10)});
    shift(2'b11, base ^ (m0 | m1), "R6 corrupt union chains");
    chk("R6 code11 matches clean", {14'd0, comp_out}, {14'd0, model(base, 2'b11)});
    shift(2'b01, base ^ 16'h0004, "R6 corrupt ungated chain2");
    checks++;
    if (comp_out === model(base, 2'b01)) begin
      errs++;
      $display("FAIL R6 ungated corruption hidden act=%h exp!=%h", comp_out, model(base, 2'b01));
    end
  endtask

  task automatic t_ignore();
    load_mask(1'b0, 16'h0F0F);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      scan_en = 1; mask_sel = 2'b00; chain_in = '0;
      mload_en = 1; mload_sel = i[0]; mload_data = 1'b1;
    end
    @(negedge clk);
    mload_en = 0;
    chk("R8 done cleared by scan", {14'd0, load_done}, 16'd0);
    probe(1'b0, "R9 mask0 unchanged by load in scan");
    probe(1'b1, "R9 mask1 unchanged by load in scan");
  endtask

  initial begin
    #1_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_plain();
    t_latency();
    t_idle();
    t_modes();
    t_xinject();
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule